// File: doc/BRIEF.md
# Host Ownership Lock Register

This block is a single configuration register through which exactly one host can claim a device. The register holds a 16-bit host identifier in the low half of a 32-bit word. The all-ones identifier 0xFFFF stands for "nobody holds the device". A host claims the device by writing its own identifier. It learns whether it won by reading the register back.

Writes are conditional, not plain stores:

- While the register is free, a write stores the written identifier.
- While it is held, a write carrying the holder's identifier frees it.
- While it is held, a write carrying any other identifier is dropped with no side effect.

Reads return the identifier in a registered word one clock after the strobe. The register answers at one word offset of a simple strobe/write-enable bus.

Top module: `hostlock_reg`

## Requirements
- R1: After synchronous reset the stored identifier is 0xFFFF (free), so a read of the register returns 0x0000FFFF, and `cfg_rdata` is 0x00000000 until the first read strobe.
- R2: A read strobe (`cfg_stb`=1, `cfg_we`=0) at the register offset loads the register word into `cfg_rdata` at the clock edge that samples the strobe. `cfg_rdata` keeps that value until the next read strobe.
- R3: While free, a write strobe at the register offset stores `cfg_wdata[15:0]`, and later reads return it.
- R4: While held, a write whose `cfg_wdata[15:0]` differs from the stored identifier leaves the register unchanged.
- R5: While held, a write whose `cfg_wdata[15:0]` equals the stored identifier frees the register, so reads return 0x0000FFFF.
- R6: After a release, a write from a different identifier acquires the register.
- R7: Only `cfg_wdata[15:0]` is compared and stored; `cfg_wdata[31:16]` has no effect. `cfg_rdata[31:16]` always reads zero.
- R8: A write of 0xFFFF while free leaves the register free.
- R9: The register sits at byte offset 0x68, decoded on `cfg_addr[23:2]`, so `cfg_addr[1:0]` is ignored. A write to any other word leaves the register unchanged. A read of any other word returns 0x00000000.
- R10: A write strobe in a cycle where `rst` is high has no effect; reset wins and the register is free afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stb | input | 1 | Access strobe, one cycle per access |
| cfg_we | input | 1 | 1 = write, 0 = read, qualified by `cfg_stb` |
| cfg_addr | input | 24 | Byte address of the access |
| cfg_wdata | input | 32 | Write data; only the low 16 bits are used |
| cfg_rdata | output | 32 | Registered read data, valid the cycle after a read strobe |

## Verification
Two of this block's functions can fall in the same cycle: the reset and the write strobe.

Reset is raised in the same cycle as a write strobe at the register offset, once while the register is free and once while it is held. A later read must return 0x0000FFFF in both cases.

The conditional-write decision is swept over every ordered pair from a set of identifiers that includes 0x0000, 0xFFFE and 0xFFFF. Each pair is applied as an acquire attempt, a second write and a repeat of the first write. After every step the bench reads the register back and compares it with an arithmetic model of the lock.

// File: rtl/hostlock_pkg.sv
package hostlock_pkg;

  // Outcome of a write that hits the lock register.
  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,  // no write this cycle
    LK_TAKE   = 2'd1,  // free: store the writer's identifier
    LK_DROP   = 2'd2,  // held by the writer: free it
    LK_REFUSE = 2'd3   // held by someone else: ignore
  } lk_act_e;

endpackage

// File: rtl/hostlock_decode.sv
module hostlock_decode #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned REG_OFS = 'h68
) (
  input  logic              cfg_stb,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic              rd_miss
);

  localparam logic [ADDR_W-1:0] OFS_V = ADDR_W'(REG_OFS);

  logic word_match;

  // Byte lanes are not decoded: word address only.
  assign word_match = (cfg_addr[ADDR_W-1:2] == OFS_V[ADDR_W-1:2]);
  assign wr_hit     = cfg_stb &&  cfg_we &&  word_match;
  assign rd_hit     = cfg_stb && !cfg_we &&  word_match;
  assign rd_miss    = cfg_stb && !cfg_we && !word_match;

endmodule

// File: rtl/hostlock_owner.sv
module hostlock_owner
  import hostlock_pkg::*;
#(
  parameter int unsigned ID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_hit,
  input  logic [ID_W-1:0] wr_id,
  output logic [ID_W-1:0] owner_q
);

  localparam logic [ID_W-1:0] FREE_ID = '1;

  lk_act_e act;
  logic    held;

  assign held = (owner_q != FREE_ID);

  always_comb begin
    if (!wr_hit)               act = LK_IDLE;
    else if (!held)            act = LK_TAKE;
    else if (wr_id == owner_q) act = LK_DROP;
    else                       act = LK_REFUSE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= FREE_ID;
    end else begin
      case (act)
        LK_TAKE: owner_q <= wr_id;
        LK_DROP: owner_q <= FREE_ID;
        default: owner_q <= owner_q;
      endcase
    end
  end

endmodule

// File: rtl/hostlock_rdport.sv
module hostlock_rdport #(
  parameter int unsigned ID_W   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic              rd_miss,
  input  logic [ID_W-1:0]   owner,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int unsigned PAD_W = (DATA_W > ID_W) ? DATA_W - ID_W : 1;

  logic [DATA_W-1:0] word;

  generate
    if (DATA_W > ID_W) begin : g_pad
      assign word = {{PAD_W{1'b0}}, owner};
    end else begin : g_trim
      assign word = owner[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_hit)  rdata_q <= word;
    else if (rd_miss) rdata_q <= '0;
  end

endmodule

// File: rtl/hostlock_reg.sv
module hostlock_reg #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ID_W    = 16,
  parameter int unsigned REG_OFS = 'h68
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_stb,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata
);

  logic            wr_hit;
  logic            rd_hit;
  logic            rd_miss;
  logic [ID_W-1:0] owner_q;

  hostlock_decode #(
    .ADDR_W (ADDR_W),
    .REG_OFS(REG_OFS)
  ) u_decode (
    .cfg_stb (cfg_stb),
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit),
    .rd_miss (rd_miss)
  );

  hostlock_owner #(
    .ID_W(ID_W)
  ) u_owner (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_hit),
    .wr_id  (cfg_wdata[ID_W-1:0]),
    .owner_q(owner_q)
  );

  hostlock_rdport #(
    .ID_W  (ID_W),
    .DATA_W(DATA_W)
  ) u_rdport (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (rd_hit),
    .rd_miss(rd_miss),
    .owner  (owner_q),
    .rdata_q(cfg_rdata)
  );

endmodule

// File: rtl/hostlock_reg_chk.sv
module hostlock_reg_chk #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ID_W    = 16,
  parameter int unsigned REG_OFS = 'h68
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_stb,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic [ID_W-1:0]   owner_q
);

  localparam logic [ADDR_W-1:0] OFS_V = ADDR_W'(REG_OFS);
  localparam logic [ID_W-1:0]   FREE  = '1;

  logic at_reg;
  logic wr_at;
  logic rd_at;

  assign at_reg = (cfg_addr[ADDR_W-1:2] == OFS_V[ADDR_W-1:2]);
  assign wr_at  = cfg_stb && cfg_we && at_reg;
  assign rd_at  = cfg_stb && !cfg_we && at_reg;

  // R1 and R10: reset frees the lock even with a write strobe present
  p_reset_free_r1: assert property (@(posedge clk)
    rst |=> (owner_q == FREE && cfg_rdata == '0));

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    rd_at |=> cfg_rdata[ID_W-1:0] == $past(owner_q));

  p_acquire_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_at && owner_q == FREE) |=> owner_q == $past(cfg_wdata[ID_W-1:0]));

  p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_at && owner_q != FREE && cfg_wdata[ID_W-1:0] != owner_q)
      |=> $stable(owner_q));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_at && owner_q != FREE && cfg_wdata[ID_W-1:0] == owner_q)
      |=> owner_q == FREE);

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata >> ID_W) == '0);

  p_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_at |=> $stable(owner_q));

endmodule

bind hostlock_reg hostlock_reg_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ID_W   (ID_W),
  .REG_OFS(REG_OFS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_stb  (cfg_stb),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .owner_q  (owner_q)
);

// File: tb/hostlock_reg_bench.sv
module hostlock_reg_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          WD_CYCLES  = 150000;
  localparam logic [23:0] REG_A      = 24'h68;
  localparam logic [15:0] FREE       = 16'hFFFF;
  localparam int          NIDS       = 10;
  localparam logic [15:0] IDS [NIDS] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
                                         16'h00FF, 16'h1234, 16'h7FFF, 16'h8000,
                                         16'hFFFE, 16'hFFFF};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_stb = 1'b0;
  logic        cfg_we = 1'b0;
  logic [23:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_owner;
  logic [31:0] rd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hostlock_reg u_hostlock_reg (
    .clk      (clk),
    .rst      (rst),
    .cfg_stb  (cfg_stb),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_stb = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_stb = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_stb = 1'b1; cfg_we = 1'b0; cfg_addr = a;
    @(negedge clk);
    cfg_stb = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_owner = FREE;
  endtask

  // Model of one conditional write; returns the requirement it exercises.
  function automatic string model_wr(input logic [15:0] id);
    if (m_owner == FREE) begin
      m_owner = id;
      return (id == FREE) ? "R8" : "R3";
    end else if (id == m_owner) begin
      m_owner = FREE;
      return "R5";
    end
    return "R4";
  endfunction

  task automatic step(input logic [15:0] id, input logic [15:0] upper);
    string tag;
    tag = model_wr(id);
    bus_wr(REG_A, {upper, id});
    bus_rd(REG_A, rd);
    chk({tag, "/R7 sweep"}, rd, {16'h0000, m_owner});
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_owner = FREE;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 rdata before first read", cfg_rdata, 32'h0);
    bus_rd(REG_A, rd);
    chk("R1 reset value", rd, 32'h0000FFFF);

    // R2: latency and hold
    bus_wr(REG_A, 32'h0000_0042);
    m_owner = 16'h0042;
    bus_rd(REG_A + 24'h4, rd);
    chk("R9 read of other word", rd, 32'h0);
    @(negedge clk);
    cfg_stb = 1'b1; cfg_we = 1'b0; cfg_addr = REG_A;
    chk("R2 no change before edge", cfg_rdata, 32'h0);
    @(posedge clk);
    #1;
    chk("R2 value after edge", cfg_rdata, 32'h0000_0042);
    @(negedge clk);
    cfg_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 value held without strobe", cfg_rdata, 32'h0000_0042);

    // R6: release then another host acquires
    bus_wr(REG_A, 32'h0000_0042);
    bus_wr(REG_A, 32'h0000_0007);
    bus_rd(REG_A, rd);
    chk("R6 second host acquires", rd, 32'h0000_0007);
    bus_wr(REG_A, 32'hFFFF_0042);
    bus_rd(REG_A, rd);
    chk("R4 refuse with upper bits set", rd, 32'h0000_0007);
    bus_wr(REG_A, 32'hABCD_0007);
    bus_rd(REG_A, rd);
    chk("R7 release ignores upper bits", rd, 32'h0000_FFFF);
    m_owner = FREE;

    // R9: other offsets and ignored byte lanes
    bus_wr(REG_A + 24'h4, 32'h0000_0011);
    bus_wr(REG_A - 24'h4, 32'h0000_0012);
    bus_wr(24'h800068, 32'h0000_0013);
    bus_rd(REG_A, rd);
    chk("R9 miss writes ignored", rd, 32'h0000_FFFF);
    bus_wr(REG_A + 24'h3, 32'h0000_0021);
    bus_rd(REG_A + 24'h1, rd);
    chk("R9 byte lanes ignored", rd, 32'h0000_0021);
    bus_wr(REG_A + 24'h2, 32'h0000_0021);
    bus_rd(REG_A, rd);
    chk("R9 release via other byte lane", rd, 32'h0000_FFFF);

    // R8: 0xFFFF while free
    bus_wr(REG_A, 32'h0000_FFFF);
    bus_rd(REG_A, rd);
    chk("R8 all-ones write stays free", rd, 32'h0000_FFFF);

    // R10: reset with a write strobe in the same cycle, free then held
    @(negedge clk);
    rst = 1'b1; cfg_stb = 1'b1; cfg_we = 1'b1; cfg_addr = REG_A; cfg_wdata = 32'h5;
    @(negedge clk);
    cfg_stb = 1'b0; cfg_we = 1'b0; rst = 1'b0;
    bus_rd(REG_A, rd);
    chk("R10 reset beats acquire", rd, 32'h0000_FFFF);
    bus_wr(REG_A, 32'h0000_0009);
    @(negedge clk);
    rst = 1'b1; cfg_stb = 1'b1; cfg_we = 1'b1; cfg_addr = REG_A; cfg_wdata = 32'h4;
    @(negedge clk);
    cfg_stb = 1'b0; cfg_we = 1'b0; rst = 1'b0;
    chk("R1 rdata cleared by reset", cfg_rdata, 32'h0);
    bus_rd(REG_A, rd);
    chk("R10 reset frees a held lock", rd, 32'h0000_FFFF);
    m_owner = FREE;

    // Pairwise sweep: R3 R4 R5 R7 R8
    for (int i = 0; i < NIDS; i++) begin
      for (int j = 0; j < NIDS; j++) begin
        step(IDS[i], IDS[i] ^ 16'h5A5A);
        step(IDS[j], ~IDS[j]);
        step(IDS[i], 16'h0000);
        if (m_owner != FREE) step(m_owner, 16'hFFFF);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule